// File: doc/BRIEF.md
# Four-Bank Asynchronous SRAM Port

This block lets a simple synchronous host reach a 32K byte space spread over four 8K x 8 asynchronous static RAM banks. The two upper address bits go through a 2-to-4 decoder that picks one active-low chip enable. The lower thirteen bits go onto a shared bank address. A single output enable, a single write enable and one shared 8-bit data bus serve all four banks. The host issues one strobe per access while `host_ready` is high. A read keeps output enable low for one cycle and returns the byte with a one-cycle `host_rvalid` pulse. A write keeps write enable low for one cycle while the host drives the bus, then spends one turnaround cycle with every strobe released.

The shared bus can be driven from either side. It is modelled as a set of drivers, one for the host and one per bank, and each driver has its own enable. The port `mem_dq` shows the value resolved from those drivers, and reads 0 when nothing drives it. A bank drives only while it is selected, output enable is low and write enable is high. The host drives only during the write cycle. Because the turnaround cycle follows every write, the host has always released the bus at least one cycle before output enable goes low.

Four behavioural bank models sit inside the block so it can be tested on its own. A model has no clock on its read path. Its storage captures on the clock edge that ends a write-enable cycle, and it is indexed by the low `MODEL_AW` bits of the bank address. If both strobes arrive together, the read goes ahead, the write is dropped, and `host_err` flags the conflict.

Top module: `sram_bank_ctrl`

## Requirements
- R1: While `rst` is high and after its release, `host_ready` is 1, `mem_ce_n` is all ones, `mem_oe_n` and `mem_we_n` are 1, and `host_rvalid`, `host_err` and `host_rdata` are 0.
- R2: During an access, host address bits [14:13] pick the bank: value k pulls `mem_ce_n[k]` low and keeps the other three high. With no access in progress, all four enables are high. Banks: 0 = 0x0000-0x1FFF, 1 = 0x2000-0x3FFF, 2 = 0x4000-0x5FFF, 3 = 0x6000-0x7FFF.
- R3: During an access, `mem_addr` equals host address bits [12:0] as captured when the strobe was accepted.
- R4: A read accepted in a ready cycle sets `mem_oe_n`=0 and `mem_we_n`=1 in the next cycle. At the end of that cycle `host_rdata` takes the stored byte and `host_rvalid` is 1 for exactly one cycle.
- R5: A write accepted in a ready cycle sets `mem_we_n`=0 and `mem_oe_n`=1 for one cycle, with `mem_dq` equal to the captured write data. It is followed by one cycle with every strobe high, the bus undriven (`mem_dq`=0) and `host_ready`=0.
- R6: Output enable is never low in a cycle in which the host drives the bus, nor in the cycle right after one.
- R7: If `host_rd` and `host_wr` are both 1 in a ready cycle, the read is performed and the write is dropped, so the addressed byte keeps its old value. `host_err` is 1 for exactly that one read cycle.
- R8: Strobes seen while `host_ready` is 0 are ignored: no extra read or write follows and `host_rvalid` stays 0.
- R9: At most one bank drives the bus, and only while output enable is low. A write to one bank leaves every byte of the other banks unchanged.
- R10: Each bank model stores a byte by the low `MODEL_AW` (default 8) bits of the bank address, so bank addresses that share those bits hold the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 15 | Byte address, bank in [14:13] |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_ready | output | 1 | High when a strobe will be accepted |
| host_rdata | output | 8 | Last byte read |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata updates |
| host_err | output | 1 | Both strobes were seen together; the write was dropped |
| mem_addr | output | 13 | Shared bank address |
| mem_ce_n | output | 4 | Active-low chip enable per bank |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_we_n | output | 1 | Shared active-low write enable |
| mem_dq | output | 8 | Resolved value of the shared data bus |

## Verification
The two host functions that can land in the same cycle are read and write, when both strobes are raised in one ready cycle. The bench does this by writing a known byte, then raising both strobes at that same address with different write data. It expects `host_err` together with a low output enable and a high write enable. It then expects the old byte to come back, both from that read and from a fresh read afterwards. A strobe raised during the write and turnaround cycles of another access is also checked, to confirm it starts nothing.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } seq_state_e;

    // Active-high internal view of the memory-side strobes.
    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
        logic host_drv;
    } strobe_t;

    function automatic strobe_t strobes_for(input seq_state_e st);
        strobe_t s;
        s = '0;
        case (st)
            ST_READ:  begin s.ce = 1'b1; s.oe = 1'b1; end
            ST_WRITE: begin s.ce = 1'b1; s.we = 1'b1; s.host_drv = 1'b1; end
            default:  s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
    import sram_bank_pkg::*;
#(
    parameter int SEL_W   = 2,
    parameter int BANK_AW = 13,
    parameter int DATA_W  = 8,
    localparam int HOST_AW = SEL_W + BANK_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [DATA_W-1:0]  bus_value,
    output logic               host_ready,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rvalid,
    output logic               host_err,
    output logic [BANK_AW-1:0] acc_addr,
    output logic [SEL_W-1:0]   acc_sel,
    output strobe_t            acc_strb,
    output logic [DATA_W-1:0]  host_drv_data
);

    seq_state_e         state;
    logic [HOST_AW-1:0] addr_q;
    logic [DATA_W-1:0]  wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            addr_q      <= '0;
            wdata_q     <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
            host_err    <= 1'b0;
        end else begin
            host_rvalid <= 1'b0;
            host_err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (host_rd) begin
                        state    <= ST_READ;
                        addr_q   <= host_addr;
                        host_err <= host_wr;
                    end else if (host_wr) begin
                        state   <= ST_WRITE;
                        addr_q  <= host_addr;
                        wdata_q <= host_wdata;
                    end
                end
                ST_READ: begin
                    host_rdata  <= bus_value;
                    host_rvalid <= 1'b1;
                    state       <= ST_IDLE;
                end
                ST_WRITE: state <= ST_TURN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign host_ready    = (state == ST_IDLE);
    assign acc_addr      = addr_q[BANK_AW-1:0];
    assign acc_sel       = addr_q[HOST_AW-1 -: SEL_W];
    assign acc_strb      = strobes_for(state);
    assign host_drv_data = wdata_q;

endmodule

// File: rtl/sram_cs_decode.sv
module sram_cs_decode #(
    parameter int SEL_W = 2,
    localparam int NBANK = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [NBANK-1:0] ce_n
);

    for (genvar i = 0; i < NBANK; i++) begin : g_dec
        assign ce_n[i] = !(en && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/sram_bank_model.sv
module sram_bank_model #(
    parameter int BANK_AW  = 13,
    parameter int DATA_W   = 8,
    parameter int MODEL_AW = 8
) (
    input  logic               clk,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic [BANK_AW-1:0] addr,
    input  logic [DATA_W-1:0]  dq_in,
    output logic               dq_en,
    output logic [DATA_W-1:0]  dq_out
);

    localparam int DEPTH = 1 << MODEL_AW;

    logic [DATA_W-1:0]   cells [DEPTH];
    logic [MODEL_AW-1:0] idx;
    logic                unused_hi;

    assign idx       = addr[MODEL_AW-1:0];
    assign unused_hi = ^addr;

    // Storage captures at the edge that closes a write-enable cycle.
    always_ff @(posedge clk) begin
        if (!ce_n && !we_n)
            cells[idx] <= dq_in;
    end

    // Read path has no clock: it follows the address while enabled.
    assign dq_en  = !ce_n && !oe_n && we_n;
    assign dq_out = dq_en ? cells[idx] : '0;

endmodule

// File: rtl/sram_bus_join.sv
module sram_bus_join #(
    parameter int NDRV   = 5,
    parameter int DATA_W = 8
) (
    input  logic [NDRV-1:0]   drv_en,
    input  logic [DATA_W-1:0] drv_data [NDRV],
    output logic [DATA_W-1:0] bus
);

    always_comb begin
        bus = '0;
        for (int i = 0; i < NDRV; i++)
            if (drv_en[i])
                bus = bus | drv_data[i];
    end

endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
    import sram_bank_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int BANK_AW  = 13,
    parameter int DATA_W   = 8,
    parameter int MODEL_AW = 8,
    localparam int NBANK   = 1 << SEL_W,
    localparam int HOST_AW = SEL_W + BANK_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               host_rd,
    input  logic               host_wr,
    output logic               host_ready,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rvalid,
    output logic               host_err,
    output logic [BANK_AW-1:0] mem_addr,
    output logic [NBANK-1:0]   mem_ce_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [DATA_W-1:0]  mem_dq
);

    strobe_t            strb;
    logic [SEL_W-1:0]   sel;
    logic [DATA_W-1:0]  host_drv_data;
    logic               host_drv_en;
    logic [NBANK-1:0]   bank_drv_en;
    logic [DATA_W-1:0]  bank_drv_data [NBANK];
    logic [NBANK:0]     all_en;
    logic [DATA_W-1:0]  all_data [NBANK+1];

    sram_seq #(.SEL_W(SEL_W), .BANK_AW(BANK_AW), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rd      (host_rd),
        .host_wr      (host_wr),
        .bus_value    (mem_dq),
        .host_ready   (host_ready),
        .host_rdata   (host_rdata),
        .host_rvalid  (host_rvalid),
        .host_err     (host_err),
        .acc_addr     (mem_addr),
        .acc_sel      (sel),
        .acc_strb     (strb),
        .host_drv_data(host_drv_data)
    );

    sram_cs_decode #(.SEL_W(SEL_W)) u_dec (
        .en  (strb.ce),
        .sel (sel),
        .ce_n(mem_ce_n)
    );

    assign mem_oe_n    = !strb.oe;
    assign mem_we_n    = !strb.we;
    assign host_drv_en = strb.host_drv;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sram_bank_model #(
            .BANK_AW(BANK_AW), .DATA_W(DATA_W), .MODEL_AW(MODEL_AW)
        ) u_bank (
            .clk   (clk),
            .ce_n  (mem_ce_n[b]),
            .oe_n  (mem_oe_n),
            .we_n  (mem_we_n),
            .addr  (mem_addr),
            .dq_in (mem_dq),
            .dq_en (bank_drv_en[b]),
            .dq_out(bank_drv_data[b])
        );
        assign all_en[b+1]   = bank_drv_en[b];
        assign all_data[b+1] = bank_drv_data[b];
    end

    assign all_en[0]   = host_drv_en;
    assign all_data[0] = host_drv_data;

    sram_bus_join #(.NDRV(NBANK + 1), .DATA_W(DATA_W)) u_bus (
        .drv_en  (all_en),
        .drv_data(all_data),
        .bus     (mem_dq)
    );

endmodule

// File: rtl/sram_bank_ctrl_chk.sv
module sram_bank_ctrl_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             host_rd,
    input logic             host_wr,
    input logic             host_ready,
    input logic             host_rvalid,
    input logic             host_err,
    input logic [NBANK-1:0] mem_ce_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic             host_drv_en,
    input logic [NBANK-1:0] bank_drv_en
);

    // R2
    ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_ce_n));

    // R2
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (&mem_ce_n));

    // R4
    rvalid_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(!mem_oe_n && mem_we_n));

    // R5
    write_turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> (mem_we_n && mem_oe_n && (&mem_ce_n) && !host_drv_en));

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!host_drv_en && !$past(host_drv_en)));

    // R7
    both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ready && host_rd && host_wr) |=> (host_err && !mem_oe_n && mem_we_n));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_err |=> !host_err);

    // R9
    single_bank_drv_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(bank_drv_en) <= 1) && ((|bank_drv_en) -> !mem_oe_n));

endmodule

bind sram_bank_ctrl sram_bank_ctrl_chk #(.NBANK(NBANK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_ready (host_ready),
    .host_rvalid(host_rvalid),
    .host_err   (host_err),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .host_drv_en(host_drv_en),
    .bank_drv_en(bank_drv_en)
);

// File: tb/sram_bank_ctrl_tb.sv
module sram_bank_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_ready, host_rvalid, host_err, mem_oe_n, mem_we_n;
    logic [7:0]  host_rdata, mem_dq;
    logic [12:0] mem_addr;
    logic [3:0]  mem_ce_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    sram_bank_ctrl u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_err(host_err),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    always #10 clk = ~clk;

    // address (15 bits) and data (8 bits): first and last byte of each bank
    localparam logic [22:0] VEC [8] = '{
        {15'h0000, 8'h11}, {15'h1FFF, 8'h22}, {15'h2000, 8'h33}, {15'h3FFF, 8'h44},
        {15'h4000, 8'h55}, {15'h5FFF, 8'h66}, {15'h6000, 8'h77}, {15'h7FFF, 8'h88}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ce_exp(input logic [14:0] a);
        return ~(4'b0001 << a[14:13]);
    endfunction

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        check("R5 we_n low", mem_we_n, 0);
        check("R5 oe_n high", mem_oe_n, 1);
        check("R5 bus carries wdata", mem_dq, d);
        check("R2 write chip enable", mem_ce_n, ce_exp(a));
        check("R3 write address", mem_addr, a[12:0]);
        host_wr = 1'b0;
        @(negedge clk);
        check("R5 turnaround strobes", {mem_we_n, mem_oe_n, mem_ce_n}, 6'h3F);
        check("R5 turnaround bus released", mem_dq, 0);
        check("R5 turnaround not ready", host_ready, 0);
        @(negedge clk);
        check("R5 ready after write", host_ready, 1);
    endtask

    task automatic do_read(input logic [14:0] a, input logic [7:0] exp, input string tag);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        check("R4 oe_n low", mem_oe_n, 0);
        check("R4 we_n high", mem_we_n, 1);
        check("R2 read chip enable", mem_ce_n, ce_exp(a));
        check("R3 read address", mem_addr, a[12:0]);
        host_rd = 1'b0;
        @(negedge clk);
        check("R4 rvalid pulse", host_rvalid, 1);
        check(tag, host_rdata, exp);
        @(negedge clk);
        check("R4 rvalid one cycle", host_rvalid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready in reset", host_ready, 1);
        check("R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 6'h3F);
        check("R1 outputs in reset", {host_rvalid, host_err, host_rdata}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", {host_ready, mem_ce_n}, 5'h1F);

        // Vector walk: write all, then read all (R9: no bank disturbs another)
        for (int i = 0; i < 8; i++) do_write(VEC[i][22:8], VEC[i][7:0]);
        for (int i = 0; i < 8; i++) do_read(VEC[i][22:8], VEC[i][7:0], "R9 R4 readback");

        // R10: shared low bits alias within a bank
        do_read(15'h0100, 8'h11, "R10 alias of 0x0000");
        do_read(15'h7EFF, 8'h88, "R10 alias of 0x7FFF");

        // R7: both strobes at once
        do_write(15'h2005, 8'h5A);
        host_addr = 15'h2005; host_wdata = 8'hC3; host_rd = 1'b1; host_wr = 1'b1;
        @(negedge clk);
        check("R7 err with read", host_err, 1);
        check("R7 read strobes", {mem_oe_n, mem_we_n}, 2'b01);
        host_rd = 1'b0; host_wr = 1'b0;
        @(negedge clk);
        check("R7 err one cycle", host_err, 0);
        check("R7 old byte returned", host_rdata, 8'h5A);
        @(negedge clk);
        do_read(15'h2005, 8'h5A, "R7 write dropped");

        // R8: strobes while busy are ignored
        host_addr = 15'h4000; host_wdata = 8'hEE; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b1; host_addr = 15'h6000;
        @(negedge clk);
        host_wr = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        check("R8 no read started", {host_rvalid, mem_oe_n}, 2'b01);
        check("R8 ready again", host_ready, 1);
        @(negedge clk);
        check("R8 still idle", {host_rvalid, mem_we_n, mem_ce_n}, 6'h1F);
        do_read(15'h6000, 8'h77, "R8 R9 bank3 untouched");
        do_read(15'h4000, 8'hEE, "R9 bank2 written");
        do_read(15'h2005, 8'h5A, "R9 bank1 untouched");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule